// File: doc/BRIEF.md
# Analog Startup Delay Controller

This block sits in front of an analog-to-digital converter's sequencer. It holds back each conversion start until every analog sub-unit that the current configuration uses has finished warming up. The five sub-units are the converter core, the gain amplifier, the internal reference, the temperature-sensor input and the internal DAC input. They warm up in parallel, so the wait is the longest warm-up among the units the configuration needs. Each warm-up is given in nanoseconds and turned into peripheral clock cycles when the design is elaborated, rounding up.

With low-latency mode off, the units power down between conversions, so every start pays the full wait. With low-latency mode on, units that have warmed up stay powered while the configuration keeps them. Later starts then launch without delay, and only units that are not yet powered add to the wait. Disabling the converter, or leaving low-latency mode, powers every unit down.

Top module: `asdc_top`

## Requirements
- R1: Unit mask bit positions are 0 converter core, 1 amplifier, 2 internal reference, 3 temperature sensor, 4 internal DAC. The wait for a set of units is the largest of their cycle counts, each equal to ceil(ns * CLK_KHZ / 1e6). With the defaults these are 40, 80, 240, 140 and 140 cycles, and an empty set waits 0 cycles.
- R2: While `slow_clk_i` is 1, the converter core counts CORE_SLOW_CYC cycles (default 20) instead of its derived count.
- R3: A start sampled while enabled and not busy, with a wait of W cycles, raises `busy_o` for exactly the next W cycles. `launch_o` then pulses for one cycle in the cycle after busy ends. When W is 0 the pulse comes in the very next cycle and `busy_o` stays low.
- R4: With `low_lat_i` at 0, every start pays the full wait of all units set in `unit_req_i`.
- R5: With `low_lat_i` at 1, a repeated start with an unchanged configuration, after a completed warm-up, launches with no wait.
- R6: With `low_lat_i` at 1, the wait equals the largest count among requested units that are not already powered. A unit dropped from `unit_req_i` stops being powered.
- R7: A start that arrives while `busy_o` is 1 is absorbed into the pending launch: exactly one `launch_o` pulse follows, and the wait is not extended.
- R8: While `enable_i` is 0, starts are ignored, `busy_o` and `launch_o` stay 0, and all powered state is cleared. The first start after re-enabling pays the full wait.
- R9: Setting `low_lat_i` to 0 clears powered state, so a later start in low-latency mode pays the full wait again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Converter enabled |
| low_lat_i | input | 1 | Keep warmed units powered between conversions |
| slow_clk_i | input | 1 | Peripheral clock is in the below-2 MHz class |
| unit_req_i | input | 5 | Analog units the current configuration needs |
| start_i | input | 1 | Conversion start request |
| busy_o | output | 1 | Warm-up in progress |
| launch_o | output | 1 | One-cycle conversion launch |

## Verification
In normal mode, every one of the 32 unit masks is tried with both clock-rate classes. The measured busy length and launch cycle therefore tell a maximum apart from a sum or from a single unit's count, and show whether the slow-clock override applies only to the core. Low-latency sequences grow and shrink the mask step by step. A correct wait that counts only newly added units is distinguished from one that recounts all units or that never charges a wait again. Start pulses sent during busy, while disabled, and right after a mode change show whether held starts, power-down on disable and power-down on mode exit behave as required.

// File: rtl/asdc_pkg.sv
package asdc_pkg;
  localparam int unsigned N_UNITS = 5;

  typedef enum int unsigned {
    U_CORE = 0,
    U_AMP  = 1,
    U_REF  = 2,
    U_TEMP = 3,
    U_DAC  = 4
  } unit_e;

  // ceil(ns * khz / 1e6)
  function automatic int unsigned ns_to_cyc(input longint unsigned ns, input longint unsigned khz);
    longint unsigned p;
    p = ns * khz;
    return int'((p + 64'd999999) / 64'd1000000);
  endfunction
endpackage

// File: rtl/asdc_warm_max.sv
module asdc_warm_max
  import asdc_pkg::*;
#(
  parameter int unsigned CNT_W         = 16,
  parameter int unsigned CORE_CYC      = 40,
  parameter int unsigned AMP_CYC       = 80,
  parameter int unsigned REF_CYC       = 240,
  parameter int unsigned TEMP_CYC      = 140,
  parameter int unsigned DAC_CYC       = 140,
  parameter int unsigned CORE_SLOW_CYC = 20
) (
  input  logic [N_UNITS-1:0] mask_i,
  input  logic               slow_i,
  output logic [CNT_W-1:0]   wait_o
);
  localparam logic [CNT_W-1:0] CYC_TAB [N_UNITS] = '{
    CNT_W'(CORE_CYC), CNT_W'(AMP_CYC), CNT_W'(REF_CYC), CNT_W'(TEMP_CYC), CNT_W'(DAC_CYC)
  };
  localparam logic [CNT_W-1:0] SLOW_CORE = CNT_W'(CORE_SLOW_CYC);

  logic [CNT_W-1:0] cand [N_UNITS];

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    if (g == int'(U_CORE)) begin : g_core
      assign cand[g] = !mask_i[g] ? '0 : (slow_i ? SLOW_CORE : CYC_TAB[g]);
    end else begin : g_other
      assign cand[g] = mask_i[g] ? CYC_TAB[g] : '0;
    end
  end

  always_comb begin
    wait_o = '0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (cand[i] > wait_o) wait_o = cand[i];
    end
  end

  always_comb begin
    AST_EMPTY_NO_WAIT: assert (mask_i != '0 || wait_o == '0); // R1
  end
endmodule

// File: rtl/asdc_warm_timer.sv
module asdc_warm_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             busy_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (clr_i)       cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o   = (cnt_q != '0);
  assign expire_o = (cnt_q == CNT_W'(1));

  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o); // R7
  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !clr_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
endmodule

// File: rtl/asdc_top.sv
module asdc_top
  import asdc_pkg::*;
#(
  parameter int unsigned CLK_KHZ       = 4000,
  parameter int unsigned CORE_NS       = 10000,
  parameter int unsigned AMP_NS        = 20000,
  parameter int unsigned REF_NS        = 60000,
  parameter int unsigned TEMP_NS       = 35000,
  parameter int unsigned DAC_NS        = 35000,
  parameter int unsigned CORE_SLOW_CYC = 20,
  parameter int unsigned CNT_W         = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic               low_lat_i,
  input  logic               slow_clk_i,
  input  logic [N_UNITS-1:0] unit_req_i,
  input  logic               start_i,
  output logic               busy_o,
  output logic               launch_o
);
  localparam int unsigned CORE_CYC = ns_to_cyc(CORE_NS, CLK_KHZ);
  localparam int unsigned AMP_CYC  = ns_to_cyc(AMP_NS, CLK_KHZ);
  localparam int unsigned REF_CYC  = ns_to_cyc(REF_NS, CLK_KHZ);
  localparam int unsigned TEMP_CYC = ns_to_cyc(TEMP_NS, CLK_KHZ);
  localparam int unsigned DAC_CYC  = ns_to_cyc(DAC_NS, CLK_KHZ);

  logic [N_UNITS-1:0] pwr_q, set_q, need;
  logic [CNT_W-1:0]   wait_cyc;
  logic               accept, load, expire, launch_q, zero_go;

  // units still cold for this start
  assign need    = low_lat_i ? (unit_req_i & ~pwr_q) : unit_req_i;
  assign accept  = enable_i && start_i && !busy_o;
  assign load    = accept && (wait_cyc != '0);
  assign zero_go = accept && (wait_cyc == '0);

  asdc_warm_max #(
    .CNT_W(CNT_W), .CORE_CYC(CORE_CYC), .AMP_CYC(AMP_CYC), .REF_CYC(REF_CYC),
    .TEMP_CYC(TEMP_CYC), .DAC_CYC(DAC_CYC), .CORE_SLOW_CYC(CORE_SLOW_CYC)
  ) i_warm_max (
    .mask_i(need),
    .slow_i(slow_clk_i),
    .wait_o(wait_cyc)
  );

  asdc_warm_timer #(.CNT_W(CNT_W)) i_warm_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (!enable_i),
    .load_i    (load),
    .load_val_i(wait_cyc),
    .busy_o    (busy_o),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      launch_q <= 1'b0;
      set_q    <= '0;
      pwr_q    <= '0;
    end else if (!enable_i) begin
      launch_q <= 1'b0;
      set_q    <= '0;
      pwr_q    <= '0;
    end else begin
      launch_q <= expire || zero_go;
      if (load) set_q <= need;
      if (!low_lat_i)  pwr_q <= '0;
      else if (expire) pwr_q <= (pwr_q & unit_req_i) | (set_q & unit_req_i);
      else             pwr_q <= pwr_q & unit_req_i;
    end
  end

  assign launch_o = launch_q;

  AST_NO_LAUNCH_IN_WARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !launch_o); // R7
  AST_LAUNCH_AFTER_WARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy_o) && $past(enable_i) && enable_i) |-> launch_o); // R3
  AST_ZERO_WAIT_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && wait_cyc == '0) |=> launch_o); // R5
  AST_DISABLED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!busy_o && !launch_o && pwr_q == '0)); // R8
  AST_NORMAL_UNPOWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !low_lat_i |=> (pwr_q == '0)); // R9
endmodule

// File: tb/test_asdc_top.sv
module test_asdc_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       enable_i = 1'b0;
  logic       low_lat_i = 1'b0;
  logic       slow_clk_i = 1'b0;
  logic [4:0] unit_req_i = '0;
  logic       start_i = 1'b0;
  logic       busy_o, launch_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  asdc_top i_asdc_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .low_lat_i(low_lat_i),
    .slow_clk_i(slow_clk_i), .unit_req_i(unit_req_i), .start_i(start_i),
    .busy_o(busy_o), .launch_o(launch_o)
  );

  function automatic int cyc(input int ns);
    return (ns * 4000 + 999999) / 1000000;
  endfunction

  function automatic int exp_wait(input logic [4:0] m, input logic slow);
    int t [5];
    int w;
    t[0] = slow ? 20 : cyc(10000);
    t[1] = cyc(20000);
    t[2] = cyc(60000);
    t[3] = cyc(35000);
    t[4] = cyc(35000);
    w = 0;
    for (int i = 0; i < 5; i++) if (m[i] && t[i] > w) w = t[i];
    return w;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // pulse start, measure busy length, check launch right after
  task automatic run_start(input string req, input int exp);
    int n = 0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk_i);
    end
    check(req, n, exp);
    check(req, int'(launch_o), 1);
    @(negedge clk_i);
    check(req, int'(launch_o), 0);
  endtask

  initial begin
    #2000000;
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    int launches;
    int n;
    repeat (3) @(negedge clk_i);
    check("R8 reset busy", int'(busy_o), 0);
    check("R8 reset launch", int'(launch_o), 0);
    rst_ni = 1'b1;

    // disabled: start ignored
    unit_req_i = 5'b00100;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    check("R8 disabled busy", int'(busy_o), 0);
    check("R8 disabled launch", int'(launch_o), 0);
    enable_i = 1'b1;

    // R1 R2 R3 R4: full sweep in normal mode
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 32; m++) begin
        slow_clk_i = s[0];
        unit_req_i = m[4:0];
        run_start($sformatf("R1 R2 R3 mask=%0d slow=%0d", m, s), exp_wait(m[4:0], s[0]));
      end
    end
    slow_clk_i = 1'b0;
    unit_req_i = 5'b01001;
    run_start("R4 repeat normal", exp_wait(5'b01001, 1'b0));
    run_start("R4 repeat normal again", exp_wait(5'b01001, 1'b0));

    // low latency
    low_lat_i = 1'b1;
    unit_req_i = 5'b00011;
    run_start("R5 first low-lat", exp_wait(5'b00011, 1'b0));
    run_start("R5 warm repeat", 0);
    unit_req_i = 5'b01011;
    run_start("R6 add temp", exp_wait(5'b01000, 1'b0));
    unit_req_i = 5'b11111;
    run_start("R6 add ref dac", exp_wait(5'b10100, 1'b0));
    run_start("R5 all warm", 0);
    unit_req_i = 5'b11011;
    run_start("R6 drop ref", 0);
    unit_req_i = 5'b11111;
    run_start("R6 re-add ref", exp_wait(5'b00100, 1'b0));

    // R9: leave and re-enter low latency
    low_lat_i = 1'b0;
    @(negedge clk_i);
    low_lat_i = 1'b1;
    run_start("R9 after mode exit", exp_wait(5'b11111, 1'b0));

    // R8: disable clears power
    enable_i = 1'b0;
    @(negedge clk_i);
    enable_i = 1'b1;
    run_start("R8 re-enable", exp_wait(5'b11111, 1'b0));

    // R8: disable mid-warm
    low_lat_i = 1'b0;
    unit_req_i = 5'b00100;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    repeat (5) @(negedge clk_i);
    enable_i = 1'b0;
    @(negedge clk_i);
    check("R8 abort busy", int'(busy_o), 0);
    launches = 0;
    repeat (300) begin
      @(negedge clk_i);
      if (launch_o) launches++;
    end
    check("R8 abort no launch", launches, 0);
    enable_i = 1'b1;

    // R7: extra starts during warm-up
    unit_req_i = 5'b00010;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    n = 0;
    launches = 0;
    while (busy_o && n < 1000) begin
      n++;
      start_i = (n % 7 == 3);
      @(negedge clk_i);
      if (launch_o) launches++;
    end
    start_i = 1'b0;
    check("R7 wait not extended", n, exp_wait(5'b00010, 1'b0));
    repeat (200) begin
      @(negedge clk_i);
      if (launch_o) launches++;
    end
    check("R7 single launch", launches, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule